// File: doc/BRIEF.md
# Prescaled Down-Count Interrupt Timer

This block is a register-programmed interval timer. A 32-bit counter is loaded from an initial-count register and counts down once per prescaled clock period. The divide ratio is a power of two from 1 to 128, chosen by a 4-bit code. When the count runs out, the block raises a one-cycle interrupt pulse. In periodic mode the counter then reloads from the initial count and keeps running. In one-shot mode it parks at zero.

Software reaches the timer through a word-addressed register bus. The bus has a write strobe, a 2-bit word select, write data, and combinational read data. There are four words: mode/vector, initial count, live count (read-only) and divide code. Writing a non-zero initial count starts or restarts the timer. Writing zero stops it. A mask bit silences the interrupt output while counting goes on, and an 8-bit vector field is kept for software.

Top module: `dct_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is idle and `irq_o` is low.
- R2: A write of a non-zero value N to word 1 (initial count) loads N into the counter at that clock edge and restarts the prescaler phase. This also applies while a count is in progress. With ratio D, the first decrement lands D clock edges after the load edge.
- R3: Word 3 holds a divide code in bits 3:0. The ratios are: code 0x0 = 2, 0x1 = 4, 0x2 = 8, 0x3 = 16, 0x8 = 32, 0x9 = 64, 0xA = 128 and 0xB = 1. The counter decrements once every D clocks.
- R4: Bit 2 of the divide code is ignored, so 0x5 behaves as 0x1 and 0xF behaves as 0xB.
- R5: In one-shot mode (word 0 bit 17 clear), `irq_o` goes high N·D clocks after the load edge. The counter then stays at zero, with no further pulses and no wrap.
- R6: In periodic mode (word 0 bit 17 set), the counter reloads the initial count at each expiry. An interrupt pulse follows every N·D clocks.
- R7: Writing zero to word 1 stops the counter at zero, at any time, and no interrupt follows.
- R8: With word 0 bit 16 set, `irq_o` stays low while the counter keeps decrementing.
- R9: Word 0 reads back bits 17, 16 and 7:0 as written (bits 7:0 form the vector), and its other bits read zero. Word 3 reads back only bits 3:0. Word 2 returns the live count, and writes to it change nothing.
- R10: Each expiry gives an interrupt pulse exactly one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_addr | input | 2 | Word select: 0 mode/vector, 1 initial count, 2 live count, 3 divide code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| irq_o | output | 1 | Interrupt pulse on expiry |

## Verification
The assertions assume that the bus writes at most one word per clock, and that `bus_addr` is valid whenever `bus_wr` is high. The bench keeps to this by driving every input on the falling edge and holding the strobe for a single cycle. The prescaler spacing property only applies while the divide code is steady. The bench therefore changes the divide code only while the timer is stopped, before a fresh load.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W = 32;
  localparam int PRE_W = 7;
  localparam int SH_W  = 3;
  localparam int VEC_W = 8;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_INIT = 2'd1,
    REG_CUR  = 2'd2,
    REG_DIV  = 2'd3
  } reg_sel_e;

  // bits {3,1,0} select ratio; index 7 is divide-by-1, others 2^(idx+1)
  function automatic logic [SH_W-1:0] div_shift(input logic [3:0] code);
    logic [2:0] idx;
    idx = {code[3], code[1:0]};
    return (idx == 3'd7) ? '0 : SH_W'(idx + 3'd1);
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int PRE_W = 7,
  parameter int SH_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    one_sh   = (PRE_W+1)'(1) << shift;
    low_mask = PRE_W'(one_sh - 1'b1);
    tick     = &(pre_q | ~low_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  // R3: a ratio above one never yields ticks on consecutive clocks
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0 && !restart) |=> (!tick || shift != $past(shift)));
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_evt
);
  assign zero_evt = tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (zero_evt)                cnt_q <= periodic ? reload_val : '0;
    else if (tick && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  a_r5_park_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && periodic) |=> cnt_q == $past(reload_val));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic [31:0]      bus_rdata,
  output logic             periodic,
  output logic             irq_mask,
  output logic [CNT_W-1:0] init_q,
  output logic [SH_W-1:0]  shift,
  output logic             load
);
  logic [VEC_W-1:0] vec_q;
  logic [3:0]       div_q;
  reg_sel_e         sel;

  assign sel   = reg_sel_e'(bus_addr);
  assign load  = bus_wr && sel == REG_INIT;
  assign shift = div_shift(div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodic <= 1'b0;
      irq_mask <= 1'b0;
      vec_q    <= '0;
      init_q   <= '0;
      div_q    <= '0;
    end else if (bus_wr) begin
      case (sel)
        REG_MODE: begin
          periodic <= bus_wdata[PERIODIC_BIT];
          irq_mask <= bus_wdata[MASK_BIT];
          vec_q    <= bus_wdata[VEC_W-1:0];
        end
        REG_INIT: init_q <= bus_wdata[CNT_W-1:0];
        REG_DIV:  div_q  <= bus_wdata[3:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_MODE: begin
        bus_rdata[PERIODIC_BIT] = periodic;
        bus_rdata[MASK_BIT]     = irq_mask;
        bus_rdata[VEC_W-1:0]    = vec_q;
      end
      REG_INIT: bus_rdata = 32'(init_q);
      REG_CUR:  bus_rdata = 32'(cur_cnt);
      default:  bus_rdata[3:0] = div_q;
    endcase
  end

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel == REG_MODE) |=> $stable(vec_q) && $stable(periodic) && $stable(irq_mask));
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  logic             periodic, irq_mask, load, tick, zero_evt;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic [SH_W-1:0]  shift;

  dct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cur_cnt(cnt_q), .bus_rdata(bus_rdata),
    .periodic(periodic), .irq_mask(irq_mask), .init_q(init_q),
    .shift(shift), .load(load)
  );

  dct_prescaler #(.PRE_W(PRE_W), .SH_W(SH_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(bus_wdata[CNT_W-1:0]),
    .reload_val(init_q), .periodic(periodic), .tick(tick),
    .cnt_q(cnt_q), .zero_evt(zero_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= zero_evt && !irq_mask;
  end

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !irq_o);
  a_r10_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(cnt_q) == CNT_W'(1) && !$past(load)));
  a_r7_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (load && bus_wdata == '0) |=> (cnt_q == '0 && !irq_o));
endmodule

// File: tb/test_dct_timer.sv
`timescale 1ns/1ps
module test_dct_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int vecs = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dct_timer i_dct_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // counts falling edges after a load until irq is seen
  task automatic wait_fire(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (irq_o) begin k = i; break; end
    end
  endtask

  task automatic count_irqs(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_o) c++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_divide;
    int codes[8] = '{0, 1, 2, 3, 8, 9, 10, 11};
    int divs[8]  = '{2, 4, 8, 16, 32, 64, 128, 1};
    int k;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 32'h0);
      wr(2'd3, 32'(codes[i]));
      wr(2'd1, 32'd3);
      wait_fire(2000, k);
      chk("R3 R5 expiry time", 32'(k), 32'(3 * divs[i]));
    end
  endtask

  task automatic t_bit2;
    int k;
    wr(2'd3, 32'h5);
    wr(2'd1, 32'd3);
    wait_fire(500, k);
    chk("R4 code 0x5 as 0x1", 32'(k), 32'd12);
    wr(2'd3, 32'hF);
    wr(2'd1, 32'd3);
    wait_fire(500, k);
    chk("R4 code 0xF as 0xB", 32'(k), 32'd3);
  endtask

  task automatic t_phase;
    logic [31:0] d;
    wr(2'd3, 32'h1);
    wr(2'd1, 32'd6);
    repeat (3) @(negedge clk);
    rd(2'd2, d);
    chk("R2 no step before D clocks", d, 32'd6);
    @(negedge clk);
    rd(2'd2, d);
    chk("R2 first step at D clocks", d, 32'd5);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_restart;
    int k;
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd50);
    repeat (20) @(negedge clk);
    wr(2'd1, 32'd10);
    wait_fire(200, k);
    chk("R2 mid-count reload", 32'(k), 32'd10);
  endtask

  task automatic t_oneshot_tail;
    int k, c;
    logic [31:0] d;
    wr(2'd0, 32'h0);
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd4);
    wait_fire(100, k);
    chk("R5 one-shot time", 32'(k), 32'd4);
    @(negedge clk);
    chk("R10 pulse one clock", 32'(irq_o), 32'h0);
    count_irqs(20, c);
    chk("R5 no second pulse", 32'(c), 32'd0);
    rd(2'd2, d);
    chk("R5 parked at zero", d, 32'd0);
  endtask

  task automatic t_periodic;
    int k;
    logic [31:0] d;
    wr(2'd0, 32'h0002_0000);
    wr(2'd3, 32'h0);
    wr(2'd1, 32'd4);
    wait_fire(100, k);
    chk("R6 first period", 32'(k), 32'd8);
    rd(2'd2, d);
    chk("R6 reloaded count", d, 32'd4);
    for (int p = 0; p < 2; p++) begin
      wait_fire(100, k);
      chk("R6 later period", 32'(k), 32'd8);
    end
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_zero;
    int c;
    logic [31:0] d;
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd100);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'd0);
    rd(2'd2, d);
    chk("R7 stopped count", d, 32'd0);
    count_irqs(300, c);
    chk("R7 no irq after stop", 32'(c), 32'd0);
  endtask

  task automatic t_mask;
    int c;
    logic [31:0] d;
    wr(2'd0, 32'h0003_0000);
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd5);
    repeat (3) @(negedge clk);
    rd(2'd2, d);
    chk("R8 counting while masked", d, 32'd2);
    count_irqs(30, c);
    chk("R8 irq suppressed", 32'(c), 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R9 mode readback", d, 32'h0003_00FF);
    wr(2'd0, 32'h0000_00A5);
    rd(2'd0, d);
    chk("R9 vector readback", d, 32'h0000_00A5);
    wr(2'd3, 32'hFFFF_FFF9);
    rd(2'd3, d);
    chk("R9 divide readback", d, 32'h9);
    wr(2'd2, 32'h1234);
    rd(2'd2, d);
    chk("R9 live count read-only", d, 32'h0);
    rd(2'd1, d);
    chk("R9 init untouched", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divide();
    t_bit2();
    t_phase();
    t_restart();
    t_oneshot_tail();
    t_periodic();
    t_zero();
    t_mask();
    t_regs();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule